// File: doc/BRIEF.md
# Static Next-Fetch Predictor with Return Stack

This front-end block looks at each fetched 32-bit RV32 instruction word together with its program counter and, one clock later, reports where fetch should go next. Conditional branches are steered by the sign of their encoded offset: a negative offset (a backward branch, usually a loop) is predicted taken and a positive one is not. Direct jumps are always taken. There are no history tables.

Calls and returns are recognised only from the register numbers in the instruction. A jump that writes register 1 is a call and records its return address on a small circular return stack. An indirect jump that writes register 0 and reads register 1 is a return and is sent to the address popped from that stack. The back end can flush the block, which empties the stack and suppresses the prediction for the fetch presented in that cycle.

Top module: `fetch_target_predictor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, pred_valid_o, pred_taken_o, pred_target_o, ras_push_o and ras_pop_o are all zero.
- R2: A fetch presented with fetch_valid_i high and flush_i low produces pred_valid_o high exactly one clock later; a cycle without a valid fetch gives all outputs zero one clock later.
- R3: A conditional branch (opcode bits 6:0 = 1100011, funct3 bits 14:12 not 010 or 011) is predicted taken exactly when bit 31 is 1, with target PC plus its offset; a forward branch predicts PC+4. funct3 010 or 011 gives no taken prediction.
- R4: The conditional-branch offset is sign-extended from bit 31, with bit 11 from bit 7, bits 10:5 from bits 30:25, bits 4:1 from bits 11:8 and bit 0 zero.
- R5: A direct jump (opcode 1101111) is always predicted taken to PC plus its offset, sign-extended from bit 31, with bits 19:12 from bits 19:12, bit 11 from bit 20, bits 10:1 from bits 30:21 and bit 0 zero.
- R6: A direct jump, or an indirect jump (opcode 1100111, funct3 000), whose destination field (bits 11:7) is 1 pushes PC+4 onto the return stack and raises ras_push_o.
- R7: An indirect jump with funct3 000, destination 0 and base field (bits 19:15) 1 on a non-empty stack pops it, raises ras_pop_o and predicts taken to the popped address. ras_push_o and ras_pop_o are never high together.
- R8: Any other indirect jump with funct3 000 is predicted not taken with target PC+4.
- R9: An indirect-jump opcode with funct3 other than 000 is ignored: no taken prediction, no push, no pop, and the stack contents are unchanged.
- R10: The return stack holds 8 entries; a push onto a full stack discards the oldest entry, so later pops return the 8 newest addresses, newest first.
- R11: A return on an empty stack predicts not taken to PC+4 with ras_pop_o low.
- R12: flush_i empties the stack, forces pred_valid_o low one clock later, and a fetch presented in the same cycle causes no push.
- R13: A non-control-flow instruction is predicted not taken with target PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | Instruction word and PC are valid this cycle |
| fetch_pc_i | input | 32 | Address of the fetched instruction |
| fetch_insn_i | input | 32 | Fetched instruction word |
| flush_i | input | 1 | Back-end redirect: clear the stack, drop this cycle's prediction |
| pred_valid_o | output | 1 | A prediction is presented |
| pred_taken_o | output | 1 | Fetch is predicted to leave the sequential path |
| pred_target_o | output | 32 | Predicted next-fetch address |
| ras_push_o | output | 1 | The predicted instruction pushed a return address |
| ras_pop_o | output | 1 | The predicted instruction popped a return address |

## Verification
The hardest state to reach is the stack wrapping: nine nested calls must be issued before any return so that the oldest entry is overwritten, and then nine returns must show eight correct addresses in reverse order followed by an empty-stack return. The stimulus builds this with a run of direct calls at distinct PCs, then drains it. A second hard case is a flush arriving with a call in the same cycle, followed by a return that must see an empty stack; the bench places both back to back. A behavioural model with a queue tracks the stack and every output is compared each cycle.

// File: rtl/ftp_pkg.sv
// Shared constants and types for the static next-fetch predictor.
// Assumes a 32-bit instruction word in the base RV32 encoding.
package ftp_pkg;
    localparam int XLEN = 32;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    localparam logic [4:0] LINK_REG = 5'd1;
    localparam logic [4:0] ZERO_REG = 5'd0;

    typedef enum logic [1:0] {
        CF_NONE,
        CF_COND,
        CF_DIRECT,
        CF_INDIRECT
    } cf_kind_e;

    typedef struct packed {
        cf_kind_e          kind;
        logic              is_call;
        logic              is_ret;
        logic              back_taken;
        logic [XLEN-1:0]   offset;
    } predecode_t;
endpackage

// File: rtl/ftp_predecode.sv
// Pure combinational pre-decode of one instruction word.
// Classifies control flow, assembles branch/jump offsets and flags calls
// and returns from register fields. Illegal encodings classify as CF_NONE.
module ftp_predecode
    import ftp_pkg::*;
(
    input  logic [XLEN-1:0] insn_i,
    output predecode_t      pd_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [XLEN-1:0] off_cond;
    logic [XLEN-1:0] off_direct;

    assign opc = insn_i[6:0];
    assign f3  = insn_i[14:12];
    assign rd  = insn_i[11:7];
    assign rs1 = insn_i[19:15];

    // Offset assembly for conditional branches and direct jumps.
    assign off_cond   = {{(XLEN-12){insn_i[31]}}, insn_i[7], insn_i[30:25], insn_i[11:8], 1'b0};
    assign off_direct = {{(XLEN-20){insn_i[31]}}, insn_i[19:12], insn_i[20], insn_i[30:21], 1'b0};

    // Classification by opcode and function field.
    always_comb begin
        pd_o = '0;
        pd_o.kind = CF_NONE;
        unique case (opc)
            OPC_BRANCH: begin
                if (f3 != 3'b010 && f3 != 3'b011) begin
                    pd_o.kind       = CF_COND;
                    pd_o.offset     = off_cond;
                    pd_o.back_taken = insn_i[31];
                end
            end
            OPC_JAL: begin
                pd_o.kind    = CF_DIRECT;
                pd_o.offset  = off_direct;
                pd_o.is_call = (rd == LINK_REG);
            end
            OPC_JALR: begin
                if (f3 == 3'b000) begin
                    pd_o.kind    = CF_INDIRECT;
                    pd_o.is_call = (rd == LINK_REG);
                    pd_o.is_ret  = (rd == ZERO_REG) && (rs1 == LINK_REG);
                end
            end
            default: pd_o.kind = CF_NONE;
        endcase
    end
endmodule

// File: rtl/ftp_return_stack.sv
// Circular return-address stack. DEPTH must be a power of two so the top
// index wraps naturally. A push on a full stack overwrites the oldest entry;
// a simultaneous pop and push replaces the top entry (pop first).
module ftp_return_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    output logic [W-1:0] top_data_o,
    output logic         empty_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] top_q;
    logic [CW-1:0] count_q;

    assign empty_o    = (count_q == '0);
    assign top_data_o = mem[top_q];

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            top_q   <= '0;
            count_q <= '0;
        end else if (push_i && !(pop_i && !empty_o)) begin
            top_q   <= top_q + 1'b1;
            count_q <= (count_q == FULL) ? count_q : count_q + 1'b1;
        end else if (pop_i && !push_i && !empty_o) begin
            top_q   <= top_q - 1'b1;
            count_q <= count_q - 1'b1;
        end
    end

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (rst_n && !clear_i && push_i) begin
            if (pop_i && !empty_o) mem[top_q] <= push_data_i;
            else                   mem[top_q + 1'b1] <= push_data_i;
        end
    end

    // R12
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> empty_o);
    // R6
    push_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clear_i) |=> !empty_o);
    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clear_i && count_q == FULL) |=> count_q == FULL);
endmodule

// File: rtl/fetch_target_predictor.sv
// Static next-fetch predictor. Pre-decodes the fetched word, applies the
// backward-taken rule, handles call/return through the return stack and
// registers the result: one cycle from fetch to prediction.
// Assumes 4-byte aligned PCs; flush has priority over any fetch.
module fetch_target_predictor
    import ftp_pkg::*;
#(
    parameter int RAS_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid_i,
    input  logic [31:0]     fetch_pc_i,
    input  logic [31:0]     fetch_insn_i,
    input  logic            flush_i,
    output logic            pred_valid_o,
    output logic            pred_taken_o,
    output logic [31:0]     pred_target_o,
    output logic            ras_push_o,
    output logic            ras_pop_o
);
    predecode_t      pd;
    logic            act;
    logic            push_req;
    logic            pop_req;
    logic            pop_ok;
    logic            ras_empty;
    logic [XLEN-1:0] ras_top;
    logic [XLEN-1:0] seq_pc;
    logic            taken_d;
    logic [XLEN-1:0] target_d;

    ftp_predecode u_predecode (
        .insn_i (fetch_insn_i),
        .pd_o   (pd)
    );

    ftp_return_stack #(.DEPTH(RAS_DEPTH), .W(XLEN)) u_ras (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (flush_i),
        .push_i      (push_req),
        .push_data_i (seq_pc),
        .pop_i       (pop_req),
        .top_data_o  (ras_top),
        .empty_o     (ras_empty)
    );

    assign act      = fetch_valid_i && !flush_i;
    assign seq_pc   = fetch_pc_i + 32'd4;
    assign push_req = act && pd.is_call;
    assign pop_req  = act && pd.is_ret;
    assign pop_ok   = pop_req && !ras_empty;

    // Direction and target selection for the current fetch.
    always_comb begin
        unique case (pd.kind)
            CF_COND:     taken_d = pd.back_taken;
            CF_DIRECT:   taken_d = 1'b1;
            CF_INDIRECT: taken_d = pop_ok;
            default:     taken_d = 1'b0;
        endcase
        if (!taken_d)               target_d = seq_pc;
        else if (pd.kind == CF_INDIRECT) target_d = ras_top;
        else                        target_d = fetch_pc_i + pd.offset;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !act) begin
            pred_valid_o  <= 1'b0;
            pred_taken_o  <= 1'b0;
            pred_target_o <= '0;
            ras_push_o    <= 1'b0;
            ras_pop_o     <= 1'b0;
        end else begin
            pred_valid_o  <= 1'b1;
            pred_taken_o  <= taken_d;
            pred_target_o <= target_d;
            ras_push_o    <= push_req;
            ras_pop_o     <= pop_ok;
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !flush_i) |=> pred_valid_o);
    // R12
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !pred_valid_o);
    // R5
    jal_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !flush_i && fetch_insn_i[6:0] == OPC_JAL) |=> pred_taken_o);
    // R3
    cond_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && !flush_i && fetch_insn_i[6:0] == OPC_BRANCH
         && fetch_insn_i[14:13] != 2'b01) |=> pred_taken_o == $past(fetch_insn_i[31]));
    // R7
    push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ras_push_o && ras_pop_o));
endmodule

// File: tb/fetch_target_predictor_tb.sv
module fetch_target_predictor_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic [31:0] fetch_insn_i = '0;
    logic        flush_i = 1'b0;
    logic        pred_valid_o, pred_taken_o, ras_push_o, ras_pop_o;
    logic [31:0] pred_target_o;

    fetch_target_predictor u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_valid_i(fetch_valid_i),
        .fetch_pc_i(fetch_pc_i), .fetch_insn_i(fetch_insn_i), .flush_i(flush_i),
        .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
        .pred_target_o(pred_target_o), .ras_push_o(ras_push_o), .ras_pop_o(ras_pop_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] ras[$];
    logic        e_valid = 0, e_taken = 0, e_push = 0, e_pop = 0;
    logic [31:0] e_target = '0;
    string       e_tag = "R1";

    function automatic logic [31:0] enc_b(int off, logic [2:0] f3);
        logic [12:0] o = off[12:0];
        return {o[12], o[10:5], 5'd6, 5'd7, f3, o[4:1], o[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(int off, logic [4:0] rd);
        logic [20:0] o = off[20:0];
        return {o[20], o[10:1], o[11], o[19:12], rd, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_jr(logic [4:0] rd, logic [4:0] rs1, logic [2:0] f3);
        return {12'h010, rs1, f3, rd, 7'b1100111};
    endfunction

    task automatic compare();
        n_tests++;
        if (pred_valid_o !== e_valid || pred_taken_o !== e_taken || pred_target_o !== e_target
            || ras_push_o !== e_push || ras_pop_o !== e_pop) begin
            n_fail++;
            $display("FAIL %s: got v=%b t=%b tgt=%h push=%b pop=%b, expected v=%b t=%b tgt=%h push=%b pop=%b",
                     e_tag, pred_valid_o, pred_taken_o, pred_target_o, ras_push_o, ras_pop_o,
                     e_valid, e_taken, e_target, e_push, e_pop);
        end
    endtask

    // Drive one cycle of stimulus; check the previous cycle's prediction first.
    task automatic step(logic v, logic [31:0] pc, logic [31:0] insn, logic fl, int off, string tag);
        logic [6:0] opc;
        logic [2:0] f3;
        logic [4:0] rd, rs1;
        @(negedge clk);
        compare();
        fetch_valid_i = v; fetch_pc_i = pc; fetch_insn_i = insn; flush_i = fl;
        e_tag = tag;
        opc = insn[6:0]; f3 = insn[14:12]; rd = insn[11:7]; rs1 = insn[19:15];
        e_valid = 0; e_taken = 0; e_target = '0; e_push = 0; e_pop = 0;
        if (fl) begin
            ras.delete();
        end else if (v) begin
            e_valid = 1;
            e_target = pc + 32'd4;
            if (opc == 7'b1100011 && f3 != 3'b010 && f3 != 3'b011) begin
                if (off < 0) begin e_taken = 1; e_target = pc + 32'(off); end
            end else if (opc == 7'b1101111) begin
                e_taken = 1; e_target = pc + 32'(off);
                if (rd == 5'd1) e_push = 1;
            end else if (opc == 7'b1100111 && f3 == 3'b000) begin
                if (rd == 5'd0 && rs1 == 5'd1 && ras.size() > 0) begin
                    e_pop = 1; e_taken = 1; e_target = ras.pop_back();
                end
                if (rd == 5'd1) e_push = 1;
            end
            if (e_push) begin
                ras.push_back(pc + 32'd4);
                if (ras.size() > 8) void'(ras.pop_front());
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values checked by the first compare
        step(1, 32'h100, 32'h00000013, 0, 0, "R13 plain instruction");
        step(0, 32'h104, 32'h00000013, 0, 0, "R2 idle cycle");
        step(1, 32'h200, enc_b(16, 3'b000), 0, 16, "R3 forward branch");
        step(1, 32'h204, enc_b(-8, 3'b001), 0, -8, "R3 backward branch");
        step(1, 32'h2000, enc_b(-4096, 3'b100), 0, -4096, "R4 min offset");
        step(1, 32'h2000, enc_b(4094, 3'b101), 0, 4094, "R4 max offset");
        step(1, 32'h3000, enc_b(-1366, 3'b110), 0, -1366, "R4 mixed bits");
        step(1, 32'h3000, enc_b(-8, 3'b010), 0, -8, "R3 illegal funct3");
        step(1, 32'h4000, enc_j(32'h12344, 5'd0), 0, 32'h12344, "R5 jump forward");
        step(1, 32'h200000, enc_j(-1048576, 5'd0), 0, -1048576, "R5 jump min");
        step(1, 32'h5000, enc_j(64, 5'd1), 0, 64, "R6 call direct");
        step(1, 32'h6000, enc_jr(5'd1, 5'd5, 3'b000), 0, 0, "R6 R8 call indirect");
        step(1, 32'h6100, enc_jr(5'd1, 5'd5, 3'b001), 0, 0, "R9 illegal call");
        step(1, 32'h6200, enc_jr(5'd0, 5'd1, 3'b011), 0, 0, "R9 illegal return");
        step(1, 32'h6300, enc_jr(5'd0, 5'd7, 3'b000), 0, 0, "R8 plain indirect");
        step(1, 32'h7000, enc_jr(5'd0, 5'd1, 3'b000), 0, 0, "R7 return pops 6004");
        step(1, 32'h7004, enc_jr(5'd0, 5'd1, 3'b000), 0, 0, "R7 return pops 5004");
        step(1, 32'h7008, enc_jr(5'd0, 5'd1, 3'b000), 0, 0, "R11 empty return");
        for (int i = 0; i < 9; i++)
            step(1, 32'h8000 + 32'(i * 256), enc_j(128, 5'd1), 0, 128, "R10 fill");
        for (int i = 0; i < 9; i++)
            step(1, 32'h9000 + 32'(i * 4), enc_jr(5'd0, 5'd1, 3'b000), 0, 0, "R10 drain");
        step(1, 32'hA000, enc_j(32, 5'd1), 0, 32, "R6 call before flush");
        step(1, 32'hB000, enc_j(32, 5'd1), 1, 32, "R12 flush with call");
        step(1, 32'hC000, enc_jr(5'd0, 5'd1, 3'b000), 0, 0, "R12 return after flush");
        step(0, 32'h0, 32'h0, 0, 0, "R2 idle end");
        @(negedge clk);
        compare();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule